// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

A compact 32-bit processor that fetches, decodes, executes and retires exactly one instruction per rising clock edge. It runs ten operations: word load and store, six register-to-register ALU operations (add, subtract, and, or, nor, signed set-on-less-than), branch-if-equal and an absolute jump. The program counter indexes an internal instruction memory. The chosen instruction reads two registers and passes through the ALU. It may then touch an internal word-addressed data memory and write one register, all within the same cycle. A single combinational decoder drives every datapath select for the current instruction.

The core has no bus to the outside. Programs and initial data are placed into its two memories by hierarchical access while reset is held. Progress is observed through registered debug outputs: the current program counter and the register-file write committed at the most recent clock edge.

Top module: `rcore_top`

## Requirements
- R1: Reset is synchronous and active high. While it is sampled high the program counter becomes 0 and the debug write-enable output reads 0.
- R2: An instruction with opcode 0x23 forms the address from register rs (bits 25:21) plus the sign-extended 16-bit immediate (bits 15:0). It writes the data word at address bits 9:2 to register rt (bits 20:16).
- R3: An instruction with opcode 0x2B writes register rt to the data word at rs plus the sign-extended immediate, and commits no register write.
- R4: Opcode 0x00 with funct (bits 5:0) 0x20, 0x22, 0x24, 0x25 or 0x27 writes rs+rt, rs-rt (modulo 2^32), rs&rt, rs|rt or ~(rs|rt) to register rd (bits 15:11).
- R5: Opcode 0x00 with funct 0x2A writes 1 to rd when rs is less than rt as signed two's complement numbers, else 0.
- R6: Opcode 0x04 sets the next PC to PC+4 plus the sign-extended immediate times 4 when rs equals rt, and to PC+4 otherwise. It commits no register write.
- R7: Opcode 0x02 sets the next PC to the upper 4 bits of PC+4 joined with bits 25:0 shifted left by 2, and commits no register write.
- R8: Register 0 reads as zero. A write aimed at it is dropped and not reported as a commit.
- R9: A register written at one edge supplies its new value to an instruction that reads it in the following cycle.
- R10: An opcode outside the set above, or an opcode 0x00 word with any other funct, writes neither registers nor memory and advances the PC by 4.
- R11: Loads, stores and ALU operations advance the PC by 4. After each edge the debug port reports the enable, register index and data of the write made at that edge, and the PC output shows the new PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_pc | output | 32 | Current program counter |
| dbg_wr_en | output | 1 | A register write was committed at the last edge |
| dbg_wr_addr | output | 5 | Register index of that write |
| dbg_wr_data | output | 32 | Value of that write |

## Verification
The ALU is swept across every ordered pair of six operand values: zero, one, all ones, the largest positive, the most negative and an irregular pattern. Each pair runs all six functions and the result goes to a rotating destination register. The sign-boundary pairs separate signed from unsigned comparison, and the wrap-around pairs expose carry and borrow handling. A second, dependent program tests the remaining behaviour. It stores and loads through a negative offset and uses a register one cycle after its write. It also writes register 0 and then reads it, runs a branch that is not taken and one that is, and a jump. It ends with both kinds of undefined encoding and a backward self-loop. A reset applied mid-run then shows that the PC returns to zero.

// File: rtl/rcore_pkg.sv
package rcore_pkg;

  localparam logic [5:0] OPC_ALU   = 6'h00;
  localparam logic [5:0] OPC_JUMP  = 6'h02;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_NOR = 6'h27;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111,
    ALU_NOR = 4'b1100
  } alu_fn_e;

  typedef struct packed {
    logic    reg_we;     // commit a register write
    logic    dst_rd;     // 1: destination rd, 0: rt
    logic    imm_opnd;   // 1: second operand is immediate
    logic    wb_mem;     // 1: write back memory data
    logic    mem_we;     // data memory write
    logic    is_branch;  // conditional branch on equality
    logic    is_jump;    // absolute jump
    alu_fn_e alu_fn;
  } ctrl_t;

endpackage

// File: rtl/rcore_alu.sv
module rcore_alu
  import rcore_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         zero
);

  logic lt_signed;
  assign lt_signed = ($signed(a) < $signed(b));

  always_comb begin
    case (fn)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, lt_signed};
      ALU_NOR: y = ~(a | b);
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/rcore_decode.sv
module rcore_decode
  import rcore_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl        = '0;
    ctrl.alu_fn = ALU_ADD;
    case (opcode)
      OPC_ALU: begin
        ctrl.dst_rd = 1'b1;
        ctrl.reg_we = 1'b1;
        case (funct)
          FN_ADD:  ctrl.alu_fn = ALU_ADD;
          FN_SUB:  ctrl.alu_fn = ALU_SUB;
          FN_AND:  ctrl.alu_fn = ALU_AND;
          FN_OR:   ctrl.alu_fn = ALU_OR;
          FN_NOR:  ctrl.alu_fn = ALU_NOR;
          FN_SLT:  ctrl.alu_fn = ALU_SLT;
          default: ctrl.reg_we = 1'b0;
        endcase
      end
      OPC_LOAD: begin
        ctrl.reg_we   = 1'b1;
        ctrl.imm_opnd = 1'b1;
        ctrl.wb_mem   = 1'b1;
      end
      OPC_STORE: begin
        ctrl.imm_opnd = 1'b1;
        ctrl.mem_we   = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.alu_fn    = ALU_SUB;
      end
      OPC_JUMP: ctrl.is_jump = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/rcore_regbank.sv
module rcore_regbank #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);

  localparam int NREG = 1 << AW;

  logic [W-1:0] regs_q [NREG];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) regs_q[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs_q[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs_q[raddr_b];

endmodule

// File: rtl/rcore_top.sv
module rcore_top
  import rcore_pkg::*;
#(
  parameter int IMEM_WORDS = 256,
  parameter int DMEM_WORDS = 256
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] dbg_pc,
  output logic        dbg_wr_en,
  output logic [4:0]  dbg_wr_addr,
  output logic [31:0] dbg_wr_data
);

  localparam int XLEN = 32;
  localparam int RAW  = 5;
  localparam int IAW  = $clog2(IMEM_WORDS);
  localparam int DAW  = $clog2(DMEM_WORDS);

  logic [XLEN-1:0] imem_q [IMEM_WORDS];
  logic [XLEN-1:0] dmem_q [DMEM_WORDS];

  initial begin
    for (int i = 0; i < IMEM_WORDS; i++) imem_q[i] = '0;
    for (int i = 0; i < DMEM_WORDS; i++) dmem_q[i] = '0;
  end

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] instr_w;
  ctrl_t           ctrl;

  assign instr_w = imem_q[pc_q[IAW+1:2]];

  logic [RAW-1:0] f_rs, f_rt, f_rd;
  assign f_rs = instr_w[25:21];
  assign f_rt = instr_w[20:16];
  assign f_rd = instr_w[15:11];

  rcore_decode u_dec (
    .opcode (instr_w[31:26]),
    .funct  (instr_w[5:0]),
    .ctrl   (ctrl)
  );

  logic [XLEN-1:0] rs_val, rt_val, wb_data;
  logic [RAW-1:0]  wb_addr;
  logic            wb_en;

  rcore_regbank #(.W(XLEN), .AW(RAW)) u_rf (
    .clk     (clk),
    .we      (wb_en),
    .waddr   (wb_addr),
    .wdata   (wb_data),
    .raddr_a (f_rs),
    .raddr_b (f_rt),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  logic [XLEN-1:0] imm_sx, alu_b, alu_y;
  logic            alu_zero;

  assign imm_sx = {{(XLEN-16){instr_w[15]}}, instr_w[15:0]};
  assign alu_b  = ctrl.imm_opnd ? imm_sx : rt_val;

  rcore_alu #(.W(XLEN)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .fn   (ctrl.alu_fn),
    .y    (alu_y),
    .zero (alu_zero)
  );

  logic [XLEN-1:0] mem_rd;
  assign mem_rd = dmem_q[alu_y[DAW+1:2]];

  always_ff @(posedge clk) begin
    if (!rst && ctrl.mem_we) dmem_q[alu_y[DAW+1:2]] <= rt_val;
  end

  assign wb_data = ctrl.wb_mem ? mem_rd : alu_y;
  assign wb_addr = ctrl.dst_rd ? f_rd : f_rt;
  assign wb_en   = !rst && ctrl.reg_we && (wb_addr != '0);

  logic [XLEN-1:0] pc_plus4, br_target, jmp_target, pc_next;
  assign pc_plus4   = pc_q + 32'd4;
  assign br_target  = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
  assign jmp_target = {pc_plus4[31:28], instr_w[25:0], 2'b00};

  always_comb begin
    if (ctrl.is_jump)                    pc_next = jmp_target;
    else if (ctrl.is_branch && alu_zero) pc_next = br_target;
    else                                 pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q        <= '0;
      dbg_wr_en   <= 1'b0;
      dbg_wr_addr <= '0;
      dbg_wr_data <= '0;
    end else begin
      pc_q        <= pc_next;
      dbg_wr_en   <= wb_en;
      dbg_wr_addr <= wb_addr;
      dbg_wr_data <= wb_data;
    end
  end

  assign dbg_pc = pc_q;

endmodule

// File: rtl/rcore_chk.sv
module rcore_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] instr,
  input logic [31:0] pc,
  input logic [31:0] dbg_pc,
  input logic        dbg_wr_en,
  input logic [4:0]  dbg_wr_addr
);

  logic [5:0] opc;
  logic       seq_op;
  assign opc    = instr[31:26];
  assign seq_op = (opc == 6'h00) || (opc == 6'h23) || (opc == 6'h2B);

  a_r1_reset_pc: assert property (@(posedge clk)
    rst |=> (dbg_pc == 32'd0 && !dbg_wr_en));

  a_r8_no_zero_commit: assert property (@(posedge clk) disable iff (rst)
    dbg_wr_en |-> (dbg_wr_addr != 5'd0));

  a_r3_store_no_write: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'h2B) |=> !dbg_wr_en);

  a_r11_seq_advance: assert property (@(posedge clk) disable iff (rst)
    seq_op |=> (dbg_pc == $past(pc) + 32'd4));

  a_r11_pc_aligned: assert property (@(posedge clk) disable iff (rst)
    dbg_pc[1:0] == 2'b00);

  a_r7_jump_no_write: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'h02) |=> !dbg_wr_en);

endmodule

bind rcore_top rcore_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .instr       (instr_w),
  .pc          (pc_q),
  .dbg_pc      (dbg_pc),
  .dbg_wr_en   (dbg_wr_en),
  .dbg_wr_addr (dbg_wr_addr)
);

// File: tb/sim_rcore_top.sv
module sim_rcore_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dbg_pc;
  logic        dbg_wr_en;
  logic [4:0]  dbg_wr_addr;
  logic [31:0] dbg_wr_data;

  always #5 clk = ~clk;

  rcore_top u0 (
    .clk         (clk),
    .rst         (rst),
    .dbg_pc      (dbg_pc),
    .dbg_wr_en   (dbg_wr_en),
    .dbg_wr_addr (dbg_wr_addr),
    .dbg_wr_data (dbg_wr_data)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt,
                                        logic [4:0] rd, logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs,
                                        logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  // one executed instruction, sampled at the following falling edge
  task automatic step_chk(input string req, input logic en, input logic [4:0] a,
                          input logic [31:0] d, input logic [31:0] pc);
    @(posedge clk);
    @(negedge clk);
    chk(req, "write en/addr", {26'd0, dbg_wr_en, (dbg_wr_en ? dbg_wr_addr : 5'd0)},
        {26'd0, en, (en ? a : 5'd0)});
    if (en) chk(req, "write data", dbg_wr_data, d);
    chk(req, "pc", dbg_pc, pc);
  endtask

  task automatic clear_imem();
    for (int i = 0; i < 256; i++) u0.imem_q[i] = 32'h0;
  endtask

  task automatic reset_and_check();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset pc", dbg_pc, 32'd0);
    chk("R1", "reset wr_en", {31'd0, dbg_wr_en}, 32'd0);
    rst = 1'b0;
  endtask

  function automatic logic [31:0] ref_alu(logic [5:0] fn, logic [31:0] a, logic [31:0] b);
    case (fn)
      6'h20:   return a + b;
      6'h22:   return a - b;
      6'h24:   return a & b;
      6'h25:   return a | b;
      6'h27:   return ~(a | b);
      default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endcase
  endfunction

  logic [31:0] vals [6];
  logic [5:0]  fns  [6];
  logic [4:0]  e_addr [256];
  logic [31:0] e_data [256];

  initial begin
    int n;
    vals = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF,
             32'h7FFF_FFFF, 32'h8000_0000, 32'h1234_ABCD};
    fns  = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h27, 6'h2A};
    #1;

    // ---------- phase 1: load operands, then ALU sweep (R2, R4, R5, R9)
    clear_imem();
    n = 0;
    for (int i = 0; i < 6; i++) begin
      u0.dmem_q[i] = vals[i];
      u0.imem_q[n] = enc_i(6'h23, 5'd0, 5'(i + 1), 16'(4 * i));
      e_addr[n] = 5'(i + 1);
      e_data[n] = vals[i];
      n++;
    end
    for (int a = 0; a < 6; a++)
      for (int b = 0; b < 6; b++)
        for (int f = 0; f < 6; f++) begin
          logic [4:0] rd;
          rd = 5'(8 + ((n - 6) % 24));
          u0.imem_q[n] = enc_r(5'(a + 1), 5'(b + 1), rd, fns[f]);
          e_addr[n] = rd;
          e_data[n] = ref_alu(fns[f], vals[a], vals[b]);
          n++;
        end
    reset_and_check();
    for (int k = 0; k < n; k++) begin
      if (k < 6) step_chk("R2", 1'b1, e_addr[k], e_data[k], 32'(4 * (k + 1)));
      else if (u0.imem_q[k][5:0] == 6'h2A)
        step_chk("R5", 1'b1, e_addr[k], e_data[k], 32'(4 * (k + 1)));
      else step_chk("R4", 1'b1, e_addr[k], e_data[k], 32'(4 * (k + 1)));
    end

    // ---------- phase 2: memory, r0, branches, jump, undefined codes
    rst = 1'b1;
    @(negedge clk);
    clear_imem();
    u0.dmem_q[0] = 32'd5;
    u0.dmem_q[1] = 32'd5;
    u0.dmem_q[2] = 32'd7;
    u0.dmem_q[3] = 32'd32;
    u0.dmem_q[6] = 32'hFFFF_FFFF;
    u0.imem_q[0]  = enc_i(6'h23, 5'd0, 5'd1, 16'd0);
    u0.imem_q[1]  = enc_i(6'h23, 5'd0, 5'd2, 16'd4);
    u0.imem_q[2]  = enc_i(6'h23, 5'd0, 5'd3, 16'd8);
    u0.imem_q[3]  = enc_i(6'h23, 5'd0, 5'd4, 16'd12);
    u0.imem_q[4]  = enc_i(6'h2B, 5'd4, 5'd3, 16'hFFF8);
    u0.imem_q[5]  = enc_i(6'h23, 5'd4, 5'd5, 16'hFFF8);
    u0.imem_q[6]  = enc_r(5'd5, 5'd1, 5'd6, 6'h20);
    u0.imem_q[7]  = enc_r(5'd1, 5'd3, 5'd0, 6'h20);
    u0.imem_q[8]  = enc_r(5'd0, 5'd3, 5'd7, 6'h25);
    u0.imem_q[9]  = enc_i(6'h04, 5'd1, 5'd3, 16'd5);
    u0.imem_q[10] = enc_i(6'h04, 5'd1, 5'd2, 16'd2);
    u0.imem_q[11] = enc_r(5'd1, 5'd1, 5'd9, 6'h20);
    u0.imem_q[12] = enc_r(5'd1, 5'd1, 5'd9, 6'h20);
    u0.imem_q[13] = {6'h02, 26'd16};
    u0.imem_q[14] = enc_r(5'd1, 5'd1, 5'd10, 6'h20);
    u0.imem_q[15] = enc_r(5'd1, 5'd1, 5'd10, 6'h20);
    u0.imem_q[16] = enc_r(5'd1, 5'd2, 5'd9, 6'h21);
    u0.imem_q[17] = enc_i(6'h3F, 5'd1, 5'd9, 16'd4);
    u0.imem_q[18] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);
    reset_and_check();
    step_chk("R2", 1'b1, 5'd1, 32'd5,  32'd4);
    step_chk("R2", 1'b1, 5'd2, 32'd5,  32'd8);
    step_chk("R2", 1'b1, 5'd3, 32'd7,  32'd12);
    step_chk("R2", 1'b1, 5'd4, 32'd32, 32'd16);
    step_chk("R3", 1'b0, 5'd0, 32'd0,  32'd20);          // store 7 to word 6
    step_chk("R3", 1'b1, 5'd5, 32'd7,  32'd24);          // read back, not FFFFFFFF
    step_chk("R9", 1'b1, 5'd6, 32'd12, 32'd28);          // r5 used next cycle
    step_chk("R8", 1'b0, 5'd0, 32'd0,  32'd32);          // write to r0 dropped
    step_chk("R8", 1'b1, 5'd7, 32'd7,  32'd36);          // r0 still reads 0
    step_chk("R6", 1'b0, 5'd0, 32'd0,  32'd40);          // not taken
    step_chk("R6", 1'b1 & 1'b0, 5'd0, 32'd0, 32'd52);    // taken to index 13
    step_chk("R7", 1'b0, 5'd0, 32'd0,  32'd64);          // jump to index 16
    step_chk("R10", 1'b0, 5'd0, 32'd0, 32'd68);          // undefined funct
    step_chk("R10", 1'b0, 5'd0, 32'd0, 32'd72);          // undefined opcode
    step_chk("R6", 1'b0, 5'd0, 32'd0,  32'd72);          // backward self loop
    step_chk("R6", 1'b0, 5'd0, 32'd0,  32'd72);
    step_chk("R11", 1'b0, 5'd0, 32'd0, 32'd72);

    // mid-run synchronous reset
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1", "mid-run reset pc", dbg_pc, 32'd0);
    chk("R1", "mid-run reset wr_en", {31'd0, dbg_wr_en}, 32'd0);
    rst = 1'b0;
    step_chk("R11", 1'b1, 5'd1, 32'd5, 32'd4);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule